// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no stored state. The word is split into equal slices, which are four bits wide by default. Inside each slice, every bit forms a generate term (both operand bits set) and a propagate term (the operand bits differ). Every carry inside the slice is then written as one flat AND-OR expression over those terms and the slice's incoming carry, so no carry inside a slice waits on the carry below it.

Between slices the carry passes serially. The top carry of one slice is the incoming carry of the next. With four slices of four bits, the path to the final carry is a few gate levels for the first slice and two more for each later slice. A plain bit-serial carry chain would need many more levels. The block is meant to sit inside a datapath that samples its result on the datapath's own clock.

Top module: `cla_grouped_adder`

## Requirements
- R1: For any operands and carry-in, the concatenation {co, s} equals the integer sum a + b + ci.
- R2: co is 1 exactly when a + b + ci is at least 2^WIDTH, for example 0x8000 + 0x8000 and 0xFFFF + 0xFFFF + 1.
- R3: The outputs follow the inputs with no clock: when all inputs are zero, s is zero and co is 0 in the same time step.
- R4: When every bit propagates (the operands are bitwise complements, or one is all ones and the other zero), co and every sum bit are set by ci alone. With ci=1, s is 0 and co is 1; with ci=0, s is all ones and co is 0.
- R5: A carry out of a slice's top bit enters the next slice at its lowest bit, for example 0x000F + 0x0001 = 0x0010 and 0x0FFF + 0x0001 = 0x1000.
- R6: A generate at the top bit of a slice sets that slice's outgoing carry whatever its incoming carry, for example 0x0008 + 0x0008 = 0x0010.
- R7: A carry stops at the first slice whose top bit neither propagates nor generates, for example 0x00FF + 0x0001 = 0x0100 with co = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | first operand |
| b | input | WIDTH | second operand |
| ci | input | 1 | carry into bit 0 |
| s | output | WIDTH | sum, modulo 2^WIDTH |
| co | output | 1 | carry out of the top bit |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between the operands and s or co. The bench changes the inputs only while the watchdog clock is low. It then waits half a clock period before it reads s and co, so each check sees fully settled combinational values and never a value caught during a change. The expected value is always the plain integer sum of the applied operands. The bench computes it itself for the random operands, and the table holds it worked out by hand for the corner operands.

// File: rtl/cla_grouped_adder.sv
module cla_grouped_adder #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] s,
  output logic             co
);
  localparam int NGRP = WIDTH / GROUP;

  if (NGRP * GROUP != WIDTH || GROUP < 1) begin : g_bad_cfg
    $error("WIDTH must be a whole multiple of GROUP");
  end

  for (genvar gi = 0; gi < NGRP; gi++) begin : grp
    localparam int BASE = gi * GROUP;
    logic [GROUP-1:0] gp, gg, gcar;
    logic             gcin;
    logic [GROUP:0]   gch;

    if (gi == 0) begin : g_first
      assign gcin = ci;
    end else begin : g_next
      assign gcin = grp[gi-1].gcar[GROUP-1];
    end

    assign gp = a[BASE +: GROUP] ^ b[BASE +: GROUP];
    assign gg = a[BASE +: GROUP] & b[BASE +: GROUP];

    always_comb begin
      for (int k = 0; k < GROUP; k++) begin
        logic acc, term;
        term = gcin;
        for (int u = 0; u <= k; u++) term = term & gp[u];
        acc = term;
        for (int t = 0; t <= k; t++) begin
          term = gg[t];
          for (int u = t + 1; u <= k; u++) term = term & gp[u];
          acc = acc | term;
        end
        gcar[k] = acc;
      end
    end

    assign gch = {gcar, gcin};
    assign s[BASE +: GROUP] = gp ^ gch[GROUP-1:0];

    always_comb begin
      if (&gp)
        p_all_prop_pass_r4: assert (gcar[GROUP-1] == gcin)
          else $error("r4: slice %0d did not pass its carry-in", gi);
      if (gg[GROUP-1])
        p_top_gen_sets_r6: assert (gcar[GROUP-1])
          else $error("r6: slice %0d lost its generated carry", gi);
      if (!gp[GROUP-1] && !gg[GROUP-1])
        p_kill_blocks_r7: assert (!gcar[GROUP-1])
          else $error("r7: slice %0d passed a killed carry", gi);
    end
  end

  assign co = grp[NGRP-1].gcar[GROUP-1];

  always_comb begin
    p_total_match_r1: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci}))
      else $error("r1: sum mismatch");
  end
endmodule

// File: tb/cla_grouped_adder_test.sv
module cla_grouped_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 10;

  // entry layout: {a[16], b[16], ci[1], expected {co,s}[17]}
  localparam logic [49:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},  // R3
    {16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R4
    {16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF},  // R4
    {16'h000F, 16'h0001, 1'b0, 17'h00010},  // R5
    {16'h0008, 16'h0008, 1'b0, 17'h00010},  // R6
    {16'h00FF, 16'h0001, 1'b0, 17'h00100},  // R7
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R2
    {16'h8000, 16'h8000, 1'b0, 17'h10000},  // R2
    {16'h1234, 16'h4321, 1'b0, 17'h05555},  // R1
    {16'hAAAA, 16'h5555, 1'b1, 17'h10000}   // R4
  };
  localparam string VTAG [NV] = '{"R3", "R4", "R4", "R5", "R6", "R7", "R2", "R2", "R1", "R4"};

  logic clk = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic ci = 1'b0;
  logic [W-1:0] s;
  logic co;
  int total = 0, bad = 0, ticks = 0;
  bit done = 0;

  cla_grouped_adder #(.WIDTH(W), .GROUP(4)) uut (.a(a), .b(b), .ci(ci), .s(s), .co(co));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > 100000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xc,
                       input logic [W:0] exp, input string req);
    @(negedge clk);
    a = xa; b = xb; ci = xc;
    #(CLK_PERIOD / 2 - 1);
    total++;
    if ({co, s} !== exp) begin
      bad++;
      $display("FAIL %s: a=%h b=%h ci=%0b actual=%h expected=%h", req, xa, xb, xc, {co, s}, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NV; i++)
      apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0], VTAG[i]);

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      int unsigned ref_sum;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      ref_sum = int'(ra) + int'(rb) + int'(rc);
      apply(ra, rb, rc, ref_sum[W:0], "R1");
    end

    apply(16'h0FFF, 16'h0001, 1'b0, 17'h01000, "R5");
    apply(16'h7FFF, 16'h0000, 1'b1, 17'h08000, "R5");
    apply(16'h5555, 16'hAAAA, 1'b0, 17'h0FFFF, "R4");
    apply(16'h0080, 16'h0080, 1'b1, 17'h00101, "R6");
    apply(16'hF0F0, 16'h0F0F, 1'b0, 17'h0FFFF, "R4");
    apply(16'h000F, 16'h0000, 1'b1, 17'h00010, "R7");
    apply(16'h0000, 16'h0000, 1'b0, 17'h00000, "R3");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule